// File: doc/BRIEF.md
# Bus-mapped parallel printer port

This block puts a Centronics-style parallel port on a simple 16-bit memory-style bus. That bus carries a 16-bit address, a write pulse, a read level and 16-bit data. The block answers at a single address, which is set by a parameter. A write to that address loads one 16-bit word, which holds the eight connector data bits, four control lines and the enable for the connector data drivers. A read from the same address returns a different 16-bit word: the five device status lines and the eight connector data lines as they appear on the pins.

The tri-state buffers are pad cells outside the block, so each tri-state point comes out as a value and an enable. The bus read path is `bus_rdata` with `bus_rdata_oe`. The connector data path is `pd_out` with `pd_oe`, and the pin level comes back on `pd_in`. When software clears the driver-enable bit, an external device can drive the data lines and software can read them. The block gives no meaning to the control or status lines. Printer timing and handshaking are left to software.

The write pulse and all pin inputs may be asynchronous to `clk`, so each passes through a two-flop synchroniser. `rst_n` is asserted asynchronously. It is expected to have been released in step with `clk` by the reset logic upstream.

Top module: `lpt_bus_port`

## Requirements
- R1: After reset every output-register bit is 0: `pd_out` is 0, the strobe, option, initialise and select lines are 0, and `pd_oe` is 0.
- R2: A write loads the output register when `bus_addr` equals `BASE_ADDR` on the third rising edge after `bus_wr` goes high. The register drives `pd_out` from bits 7..0, `ctl_strobe` from bit 8, `ctl_feed` from bit 9, `ctl_init` from bit 10, `ctl_select` from bit 11 and `pd_oe` from bit 13.
- R3: A write pulse whose address differs from `BASE_ADDR` leaves every output unchanged.
- R4: A write pulse that stays high for many cycles loads the register once, with the data present at the first load edge. Later changes of `bus_wdata` during the same pulse have no effect.
- R5: When `bus_rd` is 1 and the address matches, `bus_rdata_oe` is 1 and `bus_rdata` carries the read word.
- R6: When `bus_rd` is 0 or the address does not match, `bus_rdata_oe` is 0 and `bus_rdata` is 0.
- R7: The read word has the pin data in bits 7..0 and 0 in bits 10..8. Bit 11 is error, bit 12 on-line, bit 13 out-of-paper, bit 14 acknowledge and bit 15 busy. All of these are pin values that were held for two clock edges.
- R8: With `pd_oe` at 0, a level driven on the connector data lines by an external device is returned in bits 7..0 of the read word. With `pd_oe` at 1, the read word returns the value driven by the port.
- R9: Write bits 12, 14 and 15 have no effect on any output and are not returned by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 16 | Bus data driven toward the block |
| bus_wr | input | 1 | Write pulse, asynchronous |
| bus_rd | input | 1 | Read level |
| bus_rdata | output | 16 | Read word toward the bus pad |
| bus_rdata_oe | output | 1 | Enable for the bus data pad drivers |
| pd_out | output | 8 | Connector data value |
| pd_oe | output | 1 | Enable for the connector data drivers |
| pd_in | input | 8 | Connector data pin level |
| ctl_strobe | output | 1 | Strobe line |
| ctl_feed | output | 1 | Option (line feed) line |
| ctl_init | output | 1 | Initialise line |
| ctl_select | output | 1 | Select line |
| st_busy | input | 1 | Device busy |
| st_ack | input | 1 | Device acknowledge |
| st_paper | input | 1 | Out of paper |
| st_online | input | 1 | Device on line |
| st_error | input | 1 | Device error |

## Verification
On every cycle the assertions check the following:
- The connector outputs move only two edges after a write pulse was seen, and only at the configured address.
- A single pulse never produces two loads on consecutive edges.
- The read drivers are enabled only during a read, and the read bus is zero when they are off.
- The reserved read bits stay at zero, and each status bit equals its pin two edges earlier.

Only the bench scenarios show the rest:
- Which write data actually lands in which field.
- That a mismatched address or a held pulse leaves earlier contents alone.
- That the data lines read back an external level when the drivers are off.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  // Field positions in the word written to the port.
  localparam int unsigned WB_DATA_LSB = 0;
  localparam int unsigned WB_DATA_W   = 8;
  localparam int unsigned WB_STROBE   = 8;
  localparam int unsigned WB_FEED     = 9;
  localparam int unsigned WB_INIT     = 10;
  localparam int unsigned WB_SELECT   = 11;
  localparam int unsigned WB_DRV_EN   = 13;

  // Field positions in the word read from the port.
  localparam int unsigned RB_ERROR    = 11;
  localparam int unsigned RB_ONLINE   = 12;
  localparam int unsigned RB_PAPER    = 13;
  localparam int unsigned RB_ACK      = 14;
  localparam int unsigned RB_BUSY     = 15;

  localparam int unsigned N_STATUS    = 5;

  typedef struct packed {
    logic       drv_en;
    logic       select;
    logic       init;
    logic       feed;
    logic       strobe;
    logic [7:0] data;
  } port_ctl_t;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = d;
      end else begin : g_rest
        assign stage_d = chain_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= stage_d;
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec #(
  parameter int unsigned        ADDR_W    = 16,
  parameter logic [ADDR_W-1:0]  BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  assign hit = (addr == BASE_ADDR);
endmodule

// File: rtl/lpt_wr_capture.sv
module lpt_wr_capture #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_async,
  input  logic              hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word_q
);
  logic              wr_s;
  logic              wr_prev_q;
  logic              wr_rise;
  logic              load_en;
  logic [DATA_W-1:0] word_d;

  lpt_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_wr_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (wr_async),
    .q     (wr_s)
  );

  // Next state
  always_comb begin
    wr_rise = wr_s & ~wr_prev_q;
    load_en = wr_rise & hit;
    word_d  = load_en ? wdata : word_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      word_q    <= '0;
    end else begin
      wr_prev_q <= wr_s;
      if (load_en) word_q <= word_d;
    end
  end
endmodule

// File: rtl/lpt_bus_port.sv
module lpt_bus_port
  import lpt_pkg::*;
#(
  parameter int unsigned       ADDR_W      = 16,
  parameter int unsigned       DATA_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h3C00,
  parameter int unsigned       SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  input  logic [7:0]        pd_in,
  output logic              ctl_strobe,
  output logic              ctl_feed,
  output logic              ctl_init,
  output logic              ctl_select,
  input  logic              st_busy,
  input  logic              st_ack,
  input  logic              st_paper,
  input  logic              st_online,
  input  logic              st_error
);
  localparam int unsigned IN_W = N_STATUS + WB_DATA_W;

  logic              hit;
  logic [DATA_W-1:0] word_q;
  port_ctl_t         ctl;
  logic [IN_W-1:0]   pins_raw;
  logic [IN_W-1:0]   pins_s;
  logic [DATA_W-1:0] rd_word;

  lpt_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  lpt_wr_capture #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_async (bus_wr),
    .hit      (hit),
    .wdata    (bus_wdata),
    .word_q   (word_q)
  );

  // Unpack the stored word into connector fields; bits 12, 14, 15 unused.
  always_comb begin
    ctl.data   = word_q[WB_DATA_LSB +: WB_DATA_W];
    ctl.strobe = word_q[WB_STROBE];
    ctl.feed   = word_q[WB_FEED];
    ctl.init   = word_q[WB_INIT];
    ctl.select = word_q[WB_SELECT];
    ctl.drv_en = word_q[WB_DRV_EN];
  end

  assign pd_out     = ctl.data;
  assign pd_oe      = ctl.drv_en;
  assign ctl_strobe = ctl.strobe;
  assign ctl_feed   = ctl.feed;
  assign ctl_init   = ctl.init;
  assign ctl_select = ctl.select;

  assign pins_raw = {st_busy, st_ack, st_paper, st_online, st_error, pd_in};

  lpt_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pins_raw),
    .q     (pins_s)
  );

  // Read word assembly
  always_comb begin
    rd_word                          = '0;
    rd_word[WB_DATA_LSB +: WB_DATA_W] = pins_s[WB_DATA_W-1:0];
    rd_word[RB_ERROR]                = pins_s[WB_DATA_W + 0];
    rd_word[RB_ONLINE]               = pins_s[WB_DATA_W + 1];
    rd_word[RB_PAPER]                = pins_s[WB_DATA_W + 2];
    rd_word[RB_ACK]                  = pins_s[WB_DATA_W + 3];
    rd_word[RB_BUSY]                 = pins_s[WB_DATA_W + 4];
  end

  assign bus_rdata_oe = bus_rd & hit;
  assign bus_rdata    = bus_rdata_oe ? rd_word : '0;
endmodule

// File: rtl/lpt_bus_port_chk.sv
module lpt_bus_port_chk #(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h3C00
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rdata_oe,
  input logic [7:0]        pd_out,
  input logic              pd_oe,
  input logic              ctl_strobe,
  input logic              ctl_feed,
  input logic              ctl_init,
  input logic              ctl_select,
  input logic              st_busy,
  input logic              st_error
);
  logic [12:0] outs;
  logic [1:0]  age_q;
  logic        warm;

  assign outs = {pd_oe, ctl_select, ctl_init, ctl_feed, ctl_strobe, pd_out};
  assign warm = (age_q == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     age_q <= '0;
    else if (!warm) age_q <= age_q + 2'd1;
  end

  // R2: outputs move only two edges after the write line was high
  assert_load_follows_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$stable(outs)) |-> $past(bus_wr, 2));

  // R3: outputs move only when the configured address was on the bus
  assert_load_needs_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$stable(outs)) |-> $past(bus_addr) == BASE_ADDR);

  // R4: one pulse never gives loads on back-to-back edges
  assert_single_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !$stable(outs)) |=> $stable(outs));

  // R5: drivers on only during a read
  assert_oe_only_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata_oe |-> bus_rd);

  // R6: quiet bus when not driving
  assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_oe |-> bus_rdata == '0);

  // R7: reserved bits read zero, status bits follow their pins two edges late
  assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[10:8] == 3'b000);

  assert_busy_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && bus_rdata_oe) |-> bus_rdata[15] == $past(st_busy, 2));

  assert_error_sync_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && bus_rdata_oe) |-> bus_rdata[11] == $past(st_error, 2));
endmodule

bind lpt_bus_port lpt_bus_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .bus_rdata_oe (bus_rdata_oe),
  .pd_out       (pd_out),
  .pd_oe        (pd_oe),
  .ctl_strobe   (ctl_strobe),
  .ctl_feed     (ctl_feed),
  .ctl_init     (ctl_init),
  .ctl_select   (ctl_select),
  .st_busy      (st_busy),
  .st_error     (st_error)
);

// File: tb/sim_lpt_bus_port.sv
module sim_lpt_bus_port;
  localparam time         CLK_PERIOD = 10ns;
  localparam logic [15:0] BASE       = 16'h3C00;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_rdata;
  logic        bus_rdata_oe;
  logic [7:0]  pd_out;
  logic        pd_oe;
  logic [7:0]  pd_in;
  logic [7:0]  ext_data;
  logic        ctl_strobe, ctl_feed, ctl_init, ctl_select;
  logic        st_busy, st_ack, st_paper, st_online, st_error;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Pad model: the port wins when it drives, otherwise the device does.
  assign pd_in = pd_oe ? pd_out : ext_data;

  lpt_bus_port #(.BASE_ADDR(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .pd_out(pd_out), .pd_oe(pd_oe),
    .pd_in(pd_in), .ctl_strobe(ctl_strobe), .ctl_feed(ctl_feed),
    .ctl_init(ctl_init), .ctl_select(ctl_select), .st_busy(st_busy),
    .st_ack(st_ack), .st_paper(st_paper), .st_online(st_online),
    .st_error(st_error)
  );

  typedef struct {
    bit          is_read;
    logic [16:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    checks   = 0;
  int    failures = 0;
  bit    done     = 1'b0;

  // Scoreboard monitor: compares queued expectations at the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [16:0] act;
        it  = q.pop_front();
        act = it.is_read ? {bus_rdata_oe, bus_rdata}
                         : {4'b0, pd_oe, ctl_select, ctl_init, ctl_feed, ctl_strobe, pd_out};
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  function automatic logic [16:0] out_of(input logic [15:0] w);
    return {4'b0, w[13], w[11], w[10], w[9], w[8], w[7:0]};
  endfunction

  task automatic expect_item(input bit rd, input logic [16:0] e, input string tag);
    item_t it;
    @(posedge clk);
    it.is_read = rd; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input int hold);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    repeat (hold) @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic set_pins(input logic [4:0] st, input logic [7:0] ext);
    @(negedge clk);
    {st_busy, st_ack, st_paper, st_online, st_error} = st;
    ext_data = ext;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_expect(input logic [15:0] a, input bit rd,
                             input logic [16:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = rd;
    expect_item(1'b1, e, tag);
    bus_rd = 1'b0;
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    ext_data = '0; st_busy = 0; st_ack = 0; st_paper = 0; st_online = 0; st_error = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    expect_item(1'b0, 17'h0, "R1 reset outputs");

    // R2: two write patterns at the matching address
    do_write(BASE, 16'h2F5A, 4);
    expect_item(1'b0, out_of(16'h2F5A), "R2 write pattern A");
    do_write(BASE, 16'h0AC3, 4);
    expect_item(1'b0, out_of(16'h0AC3), "R2 write pattern B");

    // R3: mismatched address ignored
    do_write(BASE ^ 16'h0001, 16'h2FFF, 4);
    expect_item(1'b0, out_of(16'h0AC3), "R3 mismatch low bit");
    do_write(16'h0000, 16'h25AA, 4);
    expect_item(1'b0, out_of(16'h0AC3), "R3 mismatch zero address");

    // R4: long pulse loads once with first data
    @(negedge clk);
    bus_addr = BASE; bus_wdata = 16'h0911; bus_wr = 1'b1;
    repeat (5) @(negedge clk);
    bus_wdata = 16'h2EEE;
    repeat (6) @(negedge clk);
    bus_wr = 1'b0;
    repeat (3) @(negedge clk);
    expect_item(1'b0, out_of(16'h0911), "R4 held pulse keeps first data");

    // R9: unused bits have no effect on outputs
    do_write(BASE, 16'hD000 | 16'h0366, 4);
    expect_item(1'b0, out_of(16'h0366), "R9 unused write bits");

    // R8/R7: drivers off, device drives data, status pattern
    set_pins(5'b10101, 8'hC3);
    read_expect(BASE, 1'b1, {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 3'b000, 8'hC3},
                "R8 R7 readback with drivers off");
    set_pins(5'b01010, 8'h3C);
    read_expect(BASE, 1'b1, {1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 8'h3C},
                "R7 status pattern two");

    // R8: drivers on, read returns port value
    do_write(BASE, 16'h2000 | 16'h00A5, 4);
    expect_item(1'b0, out_of(16'h20A5), "R2 drivers enabled");
    set_pins(5'b11111, 8'h0F);
    read_expect(BASE, 1'b1, {1'b1, 5'b11111, 3'b000, 8'hA5}, "R8 R5 readback with drivers on");

    // R6: no drive without read or without match
    read_expect(BASE, 1'b0, 17'h0, "R6 read line low");
    read_expect(BASE + 16'h0010, 1'b1, 17'h0, "R6 read at other address");

    // R9: unused write bits never appear in the read word
    set_pins(5'b00000, 8'h00);
    read_expect(BASE, 1'b1, {1'b1, 5'b00000, 3'b000, 8'hA5}, "R9 R7 unused bits read zero");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule